// File: doc/BRIEF.md
# PTP Two-Step Timestamp Tag Return

This block sits beside a transmit datapath and returns transmit timestamps to the client. At the ingress point of the stream, every start-of-frame beat carries a 2-bit operation code and a 16-bit client tag. If the code asks for a timestamp, the tag goes into a small in-order queue. Nothing else is stored. The frame itself passes through untouched.

Later, the same frame's start of frame reaches the capture plane. The datapath signals this with a capture strobe that carries the frame's operation code again. If that code asks for a timestamp, the block pops the oldest queued tag. It then pairs the tag with the 80-bit system time read on that same clock edge. The timer uses the same clock as the stream. The pair is presented on the result outputs one cycle later, with a valid pulse that lasts exactly one clock.

Two faults are recorded in status flags:
- A tag that arrives while the queue is full is discarded.
- A capture that finds the queue empty produces no result.

Each fault sets its own flag. The flags hold until the synchronous active-low reset.

Top module: `ptp_tag_return`

## Requirements
- R1: While reset is held and in the first cycle after it, the result valid output is 0 and both error flags are 0.
- R2: Operation code 2'b00 takes no timestamp. At ingress its tag is not queued. At the capture plane it pops nothing and raises no result.
- R3: Operation code 2'b11 behaves exactly as 2'b00, at both ingress and the capture plane.
- R4: Codes 2'b01 and 2'b10 queue the tag at ingress. At the capture plane they pop it. In the next cycle the block shows valid=1, the popped tag, and the 80-bit system time sampled on the capture cycle, bit for bit.
- R5: Each successful capture yields exactly one cycle of valid. A cycle without a successful capture in the previous cycle shows valid=0. At most one result is emitted per cycle.
- R6: Tags come out in the order they were queued at ingress.
- R7: The queue holds 8 tags. A stamping ingress beat with 8 tags held and no pop in the same cycle is dropped and sets the write error flag. The held tags are unaffected.
- R8: A stamping capture with the queue empty sets the read error flag and gives no valid pulse.
- R9: Both error flags stay set until reset, and reset clears them and empties the queue.
- R10: A push and a pop in the same cycle on a full queue both succeed, with no write error. On an empty queue, the pop fails with a read error and the push is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock; the system timer is in this domain |
| rst_n | input | 1 | Synchronous active-low reset of the transmit path |
| tx_sof | input | 1 | Start-of-frame beat at the ingress point |
| tx_op | input | 2 | Operation code of that frame (00 none, 01 one-step, 10 two-step, 11 reserved) |
| tx_tag | input | 16 | Client tag of that frame |
| cap_sof | input | 1 | Start of frame crossing the capture plane |
| cap_op | input | 2 | Operation code of the frame at the capture plane |
| sys_time | input | 80 | System timer, 48-bit seconds over 32-bit nanoseconds |
| ts_valid | output | 1 | One-cycle pulse marking a result |
| ts_tag | output | 16 | Tag of the stamped frame |
| ts_time | output | 80 | Time at which the frame crossed the capture plane |
| tag_wr_err | output | 1 | Sticky: tag dropped on a full queue |
| tag_rd_err | output | 1 | Sticky: capture found the queue empty |

## Verification
The assertions assume the following about the inputs:
- `sys_time` is already synchronous to `clk`.
- The capture strobe carries the same operation code the frame had at ingress.
- Frames reach the capture plane in ingress order.

Under those assumptions, each result's time must equal the timer value one cycle earlier, and a result may only follow a stamping capture. The stimulus keeps to these assumptions in the ordinary sweeps. It breaks them on purpose only where a requirement asks for the fault: captures with no matching queued tag, and ingress bursts beyond the queue depth.

// File: rtl/ptp_tag_pkg.sv
`timescale 1ns/1ps
// Package: shared operation-code type and decode for the tag return path.
// Assumes the 2-bit code values are fixed by the client interface.
package ptp_tag_pkg;

    typedef enum logic [1:0] {
        OP_NONE     = 2'b00,
        OP_ONE_STEP = 2'b01,
        OP_TWO_STEP = 2'b10,
        OP_RESERVED = 2'b11
    } ts_op_e;

    // True when the code requests a timestamp; reserved acts as none.
    function automatic logic op_takes_stamp(input logic [1:0] op);
        logic res;
        case (ts_op_e'(op))
            OP_ONE_STEP: res = 1'b1;
            OP_TWO_STEP: res = 1'b1;
            default:     res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/ptp_op_gate.sv
`timescale 1ns/1ps
// Module: ptp_op_gate
// Turns the ingress and capture-plane strobes into queue push/pop requests.
// Assumes each strobe is a single-cycle beat qualified by its own op code.
module ptp_op_gate
    import ptp_tag_pkg::*;
(
    input  logic       tx_sof,
    input  logic [1:0] tx_op,
    input  logic       cap_sof,
    input  logic [1:0] cap_op,
    output logic       push_req,
    output logic       pop_req
);

    // Only stamping codes reach the queue.
    always_comb begin
        push_req = tx_sof  && op_takes_stamp(tx_op);
        pop_req  = cap_sof && op_takes_stamp(cap_op);
    end

endmodule

// File: rtl/ptp_tag_fifo.sv
`timescale 1ns/1ps
// Module: ptp_tag_fifo
// In-order tag queue. A push on a full queue is refused unless a pop
// happens in the same cycle. A pop on an empty queue is refused, and the
// two refusals are reported as one-cycle strobes.
// Assumes DEPTH >= 2. Storage is not reset; only the pointers are.
module ptp_tag_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [W-1:0]  wdata,
    input  logic          pop_req,
    output logic [W-1:0]  rdata,
    output logic          pop_ok,
    output logic          push_drop,
    output logic          pop_miss,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;

    // Occupancy flags and accept/refuse decisions for this cycle.
    always_comb begin
        empty     = (count == '0);
        full      = (count == CW'(DEPTH));
        pop_ok    = pop_req && !empty;
        pop_miss  = pop_req && empty;
        push_ok   = push_req && (!full || pop_ok);
        push_drop = push_req && full && !pop_ok;
        rdata     = mem[rd_ptr];
    end

    // Store an accepted tag at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance pointers with wrap and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

endmodule

// File: rtl/ptp_sticky_flags.sv
`timescale 1ns/1ps
// Module: ptp_sticky_flags
// A bank of N error flags. A flag sets on its strobe and holds until reset.
// Assumes the reset is the transmit path reset and is synchronous.
module ptp_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    output logic [N-1:0] flag
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Latch bit g on its strobe; only reset releases it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag[g] <= 1'b0;
            end else if (set[g]) begin
                flag[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ptp_ts_out.sv
`timescale 1ns/1ps
// Module: ptp_ts_out
// Result register. It pairs the popped tag with the timer value of the
// capture cycle, shows them one cycle later, and raises a one-cycle valid.
// Assumes at most one fire per cycle.
module ptp_ts_out #(
    parameter int TAG_W  = 16,
    parameter int TIME_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [TIME_W-1:0] time_in,
    output logic              valid,
    output logic [TAG_W-1:0]  tag_out,
    output logic [TIME_W-1:0] time_out
);

    // Valid follows fire for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= fire;
        end
    end

    // Capture the tag and time only on a successful pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_out  <= '0;
            time_out <= '0;
        end else if (fire) begin
            tag_out  <= tag_in;
            time_out <= time_in;
        end
    end

endmodule

// File: rtl/ptp_tag_return.sv
`timescale 1ns/1ps
// Module: ptp_tag_return (top)
// Queues client tags of stamping frames at ingress. When the frame crosses
// the capture plane, it pops the tag, pairs it with the system time and
// returns the pair to the client. Frames are never modified.
// Assumes sys_time is synchronous to clk, and that frames reach the capture
// plane in ingress order with an unchanged op code.
module ptp_tag_return #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 16,
    parameter int TIME_W = 80,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_sof,
    input  logic [1:0]        tx_op,
    input  logic [TAG_W-1:0]  tx_tag,
    input  logic              cap_sof,
    input  logic [1:0]        cap_op,
    input  logic [TIME_W-1:0] sys_time,
    output logic              ts_valid,
    output logic [TAG_W-1:0]  ts_tag,
    output logic [TIME_W-1:0] ts_time,
    output logic              tag_wr_err,
    output logic              tag_rd_err
);

    logic             push_req;
    logic             pop_req;
    logic             pop_ok;
    logic             push_drop;
    logic             pop_miss;
    logic [TAG_W-1:0] head_tag;
    logic [CW-1:0]    fifo_count;
    logic             fifo_empty;
    logic             fifo_full;
    logic [1:0]       err_set;
    logic [1:0]       err_flag;

    ptp_op_gate u_gate (
        .tx_sof   (tx_sof),
        .tx_op    (tx_op),
        .cap_sof  (cap_sof),
        .cap_op   (cap_op),
        .push_req (push_req),
        .pop_req  (pop_req)
    );

    ptp_tag_fifo #(.DEPTH(DEPTH), .W(TAG_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .wdata     (tx_tag),
        .pop_req   (pop_req),
        .rdata     (head_tag),
        .pop_ok    (pop_ok),
        .push_drop (push_drop),
        .pop_miss  (pop_miss),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    // Bit 0 records dropped writes, bit 1 records failed reads.
    always_comb begin
        err_set = {pop_miss, push_drop};
    end

    ptp_sticky_flags #(.N(2)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .flag  (err_flag)
    );

    ptp_ts_out #(.TAG_W(TAG_W), .TIME_W(TIME_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (pop_ok),
        .tag_in   (head_tag),
        .time_in  (sys_time),
        .valid    (ts_valid),
        .tag_out  (ts_tag),
        .time_out (ts_time)
    );

    // Route the flag bank to the status ports.
    always_comb begin
        tag_wr_err = err_flag[0];
        tag_rd_err = err_flag[1];
    end

endmodule

// File: rtl/ptp_tag_return_chk.sv
`timescale 1ns/1ps
// Module: ptp_tag_return_chk
// Property checker for ptp_tag_return, attached by bind below.
// Assumes a synchronous active-low reset; every property is off during it.
module ptp_tag_return_chk #(
    parameter int DEPTH  = 8,
    parameter int TIME_W = 80,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_sof,
    input  logic [1:0]        tx_op,
    input  logic              cap_sof,
    input  logic [1:0]        cap_op,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              ts_valid,
    input  logic [TIME_W-1:0] ts_time,
    input  logic              tag_wr_err,
    input  logic              tag_rd_err,
    input  logic [CW-1:0]     fifo_count,
    input  logic              fifo_empty,
    input  logic              fifo_full
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ts_valid && !tag_wr_err && !tag_rd_err));

    // R2
    noop_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_sof && cap_op == 2'b00) |=> !ts_valid);

    // R2
    noop_ingress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof && tx_op == 2'b00) |=> fifo_count <= $past(fifo_count));

    // R3
    rsvd_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_sof && cap_op == 2'b11) |=> !ts_valid);

    // R3
    rsvd_ingress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof && tx_op == 2'b11) |=> fifo_count <= $past(fifo_count));

    // R4
    stamp_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |-> ts_time == $past(sys_time));

    // R5
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |-> ($past(cap_sof) && ($past(cap_op) == 2'b01 || $past(cap_op) == 2'b10)));

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R7
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && tx_sof && (tx_op == 2'b01 || tx_op == 2'b10) && !cap_sof) |=> tag_wr_err);

    // R8
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && cap_sof && (cap_op == 2'b01 || cap_op == 2'b10)) |=> (!ts_valid && tag_rd_err));

    // R9
    wr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr_err |=> tag_wr_err);

    // R9
    rd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_rd_err |=> tag_rd_err);

endmodule

bind ptp_tag_return ptp_tag_return_chk #(
    .DEPTH  (DEPTH),
    .TIME_W (TIME_W),
    .CW     (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_sof     (tx_sof),
    .tx_op      (tx_op),
    .cap_sof    (cap_sof),
    .cap_op     (cap_op),
    .sys_time   (sys_time),
    .ts_valid   (ts_valid),
    .ts_time    (ts_time),
    .tag_wr_err (tag_wr_err),
    .tag_rd_err (tag_rd_err),
    .fifo_count (fifo_count),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full)
);

// File: tb/tb_ptp_tag_return.sv
`timescale 1ns/1ps
// Bench for ptp_tag_return. Inputs are driven, and outputs sampled, 5 ns
// after each rising edge. Expectations come from a queue built from the
// requirements.
module tb_ptp_tag_return;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_sof = 1'b0;
    logic [1:0]  tx_op = 2'b00;
    logic [15:0] tx_tag = '0;
    logic        cap_sof = 1'b0;
    logic [1:0]  cap_op = 2'b00;
    logic [79:0] sys_time = '0;
    logic        ts_valid;
    logic [15:0] ts_tag;
    logic [79:0] ts_time;
    logic        tag_wr_err;
    logic        tag_rd_err;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          cyc_n   = 0;
    bit          done    = 1'b0;
    logic [15:0] mq[$];
    logic        exp_wr = 1'b0;
    logic        exp_rd = 1'b0;

    always #10 clk = ~clk;

    ptp_tag_return dut (
        .clk(clk), .rst_n(rst_n), .tx_sof(tx_sof), .tx_op(tx_op),
        .tx_tag(tx_tag), .cap_sof(cap_sof), .cap_op(cap_op),
        .sys_time(sys_time), .ts_valid(ts_valid), .ts_tag(ts_tag),
        .ts_time(ts_time), .tag_wr_err(tag_wr_err), .tag_rd_err(tag_rd_err)
    );

    function automatic bit stamps(input logic [1:0] op);
        return (op == 2'b01) || (op == 2'b10);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input string req);
        rst_n = 1'b0; tx_sof = 1'b0; cap_sof = 1'b0;
        tx_op = 2'b00; cap_op = 2'b00;
        repeat (2) @(posedge clk);
        #5;
        chk(req, "valid in reset", ts_valid, 0);
        chk(req, "wr_err in reset", tag_wr_err, 0);
        chk(req, "rd_err in reset", tag_rd_err, 0);
        rst_n = 1'b1;
        mq.delete(); exp_wr = 1'b0; exp_rd = 1'b0;
        @(posedge clk); #5;
        chk(req, "valid after reset", ts_valid, 0);
        chk(req, "wr_err after reset", tag_wr_err, 0);
        chk(req, "rd_err after reset", tag_rd_err, 0);
    endtask

    // One clock: drive the beats, predict, step, compare.
    task automatic step(input string req, input logic s, input logic [1:0] o,
                        input logic [15:0] t, input logic c, input logic [1:0] co);
        logic        ev;
        logic [15:0] etag;
        logic [79:0] etime;
        cyc_n++;
        etime = {48'(cyc_n * 3), 32'(cyc_n * 101)};
        sys_time = etime;
        tx_sof = s; tx_op = o; tx_tag = t; cap_sof = c; cap_op = co;
        ev = 1'b0; etag = '0;
        if (c && stamps(co)) begin
            if (mq.size() == 0) exp_rd = 1'b1;
            else begin ev = 1'b1; etag = mq.pop_front(); end
        end
        if (s && stamps(o)) begin
            if (mq.size() < 8) mq.push_back(t);
            else exp_wr = 1'b1;
        end
        @(posedge clk); #5;
        tx_sof = 1'b0; cap_sof = 1'b0;
        chk(req, "valid", ts_valid, ev);
        if (ev) begin
            chk(req, "tag", ts_tag, etag);
            chk(req, "time", ts_time, etime);
        end
        chk(req, "wr_err", tag_wr_err, exp_wr);
        chk(req, "rd_err", tag_rd_err, exp_rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R1");

        // R2 R3 R4 R8: every ingress code against every capture code
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                string lbl;
                lbl = (a == 3 || b == 3) ? "R3" : (a == 0 || b == 0) ? "R2" : "R4";
                do_reset("R1");
                step(lbl, 1'b1, 2'(a), 16'(16'hA000 + a * 16 + b), 1'b0, 2'b00);
                step((stamps(2'(b)) && !stamps(2'(a))) ? "R8" : lbl,
                     1'b0, 2'b00, '0, 1'b1, 2'(b));
                step("R5", 1'b0, 2'b00, '0, 1'b0, 2'b00);
            end
        end

        // R7 R6: overfill by one, drain in order, then underflow (R8)
        do_reset("R1");
        for (int i = 0; i < 9; i++) step("R7", 1'b1, 2'(1 + i % 2), 16'(16'h1100 + i), 1'b0, 2'b00);
        for (int i = 0; i < 8; i++) step("R6", 1'b0, 2'b00, '0, 1'b1, 2'(1 + i % 2));
        step("R8", 1'b0, 2'b00, '0, 1'b1, 2'b10);
        for (int i = 0; i < 4; i++) step("R9", 1'b0, 2'b00, '0, 1'b0, 2'b00);
        do_reset("R9");
        step("R9", 1'b0, 2'b00, '0, 1'b1, 2'b01);

        // R10: full queue with simultaneous push and pop
        do_reset("R1");
        for (int i = 0; i < 8; i++) step("R10", 1'b1, 2'b10, 16'(16'h2200 + i), 1'b0, 2'b00);
        step("R10", 1'b1, 2'b01, 16'h22FF, 1'b1, 2'b01);
        for (int i = 0; i < 8; i++) step("R10", 1'b0, 2'b00, '0, 1'b1, 2'b10);

        // R10: empty queue with simultaneous push and pop
        do_reset("R1");
        step("R10", 1'b1, 2'b01, 16'h3333, 1'b1, 2'b10);
        step("R10", 1'b0, 2'b00, '0, 1'b1, 2'b01);

        // R6 R5: mixed traffic, back-to-back results
        do_reset("R1");
        for (int i = 0; i < 300; i++) begin
            step("R6", (i % 3) != 2, 2'((i * 7 + i / 5) % 4), 16'(i * 257 + 5),
                 (i % 4) != 0 && i > 2, 2'((i * 5 + 1) % 4));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule